// File: doc/BRIEF.md
# Transmit Hold Queue and Descriptor Ring Scheduler

This block sits between the packet-switching logic and an outbound media controller. Outgoing packets arrive as buffer handles on an enqueue port. Each handle is either linked straight into a small circular ring of transmit descriptors, parked in an in-order hold queue that sits in front of that ring, or refused when the hold queue has no room. The media controller watches the oldest ready descriptor. After it has sent the packet, it reports completion.

A completion retires the oldest descriptor and clears its ready bit. One cycle later the block emits the retired buffer handle on a release output, and that pulse is the transmit-complete event. On the same edge, the oldest held packet is moved into the slot that was freed. A new packet can bypass the hold queue only when the hold queue is empty, so the controller always sees packets in the order they were accepted. The block counts refused packets and reports how many descriptors and how many held packets are outstanding.

Top module: `txhq_ring_sched`

## Requirements
- R1: After reset, ring_count, hold_count and drop_count read zero, and ctl_desc_ready and rel_valid are low.
- R2: When the hold queue is empty and the ring has a free descriptor after any same-cycle completion, an offered packet is accepted (enq_accept high in that cycle) and ring_count rises by one at the next edge.
- R3: When the hold queue holds packets after any same-cycle refill, an offered packet is accepted into the tail of the hold queue and is never placed ahead of earlier packets.
- R4: When the hold queue is empty and the ring is full, an offered packet is accepted into the hold queue, and hold_count rises by one.
- R5: When the hold queue is full after any same-cycle refill, an offered packet is refused: enq_drop is high and enq_accept low in that cycle, and drop_count rises by one at the next edge, saturating at its all-ones value.
- R6: ctl_desc_ready is high exactly when at least one descriptor is ready, and ctl_desc_handle then shows the oldest accepted packet that has not yet completed.
- R7: A ctl_done sampled while ctl_desc_ready is high produces, one cycle later, a one-cycle rel_valid pulse carrying the handle that was shown. A ctl_done sampled while ctl_desc_ready is low is ignored: no release follows and no count changes.
- R8: A completion that occurs while the hold queue is non-empty moves the oldest held packet into the ring on the same edge, so ring_count stays the same and hold_count falls by one.
- R9: When an enqueue and a completion fall in the same cycle, the refill from the hold queue is taken first and the new packet is then routed by R2 to R5 against the occupancy left after that refill.
- R10: ring_count equals the number of descriptors whose ready bit is set, and hold_count equals the number of held packets. Whenever hold_count is non-zero, ring_count equals the ring depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A packet handle is offered this cycle |
| enq_handle | input | HANDLE_W | Buffer handle of the offered packet |
| enq_accept | output | 1 | Offered packet is taken (ring or hold queue) |
| enq_drop | output | 1 | Offered packet is refused |
| ctl_desc_ready | output | 1 | Oldest descriptor is ready for the controller |
| ctl_desc_handle | output | HANDLE_W | Buffer handle in the oldest ready descriptor |
| ctl_done | input | 1 | Controller finished sending the oldest descriptor |
| rel_valid | output | 1 | Transmit-complete event; a buffer handle is released |
| rel_handle | output | HANDLE_W | Handle being released |
| ring_count | output | $clog2(RING_DEPTH+1) | Ready descriptors in the ring |
| hold_count | output | $clog2(HOLD_DEPTH+1) | Packets waiting in the hold queue |
| drop_count | output | DROP_W | Saturating count of refused packets |

## Verification
A scoreboard keeps every accepted handle in arrival order. Each release and each value shown to the controller must match the head of that list, which exposes any reordering between direct links and held packets. The stimulus fills the ring one packet per cycle, which separates direct linking from holding. It then fills the hold queue to overflow, which separates holding from refusal. It drives completions both alone and in the same cycle as an enqueue, with the hold queue full, with exactly one packet held and with it empty, because those cases tell whether the refill is taken before the new packet is routed. A completion on an empty ring, followed by an interleaved enqueue/completion pattern, shows that stray completions are ignored and that occupancy tracking stays right under mixed traffic.

// File: rtl/txhq_pkg.sv
package txhq_pkg;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_RING = 2'd1,
    RT_HOLD = 2'd2,
    RT_DROP = 2'd3
  } route_e;

  // Next index of a circular structure of the given depth.
  function automatic int wrap_inc(int p, int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Routing of an offered packet against occupancy left after any refill.
  function automatic route_e pick_route(logic offered, int hold_after, int ring_after,
                                        int hold_depth, int ring_depth);
    if (!offered)                                    return RT_NONE;
    if (hold_after == 0 && ring_after < ring_depth) return RT_RING;
    if (hold_after < hold_depth)                     return RT_HOLD;
    return RT_DROP;
  endfunction

endpackage

// File: rtl/txhq_hold_fifo.sv
module txhq_hold_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  import txhq_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = store[rd_ptr];
  assign count = cnt_q;

endmodule

// File: rtl/txhq_desc_ring.sv
module txhq_desc_ring #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       link_en,
  input  logic [W-1:0]               link_handle,
  input  logic                       done_req,
  output logic                       retire_ok,
  output logic                       head_ready,
  output logic [W-1:0]               head_handle,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  import txhq_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]     slot [DEPTH];
  logic [DEPTH-1:0] ready_q;
  logic [PW-1:0]    head_ptr, tail_ptr;

  assign head_ready  = ready_q[head_ptr];
  assign head_handle = slot[head_ptr];
  assign retire_ok   = done_req & head_ready;
  assign count       = CW'($countones(ready_q));

  always_ff @(posedge clk) begin
    if (link_en) slot[tail_ptr] <= link_handle;
  end

  // Retire first, link second: when the ring is full the freed head slot
  // is also the tail, and the new link must win.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= '0;
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      if (retire_ok) begin
        ready_q[head_ptr] <= 1'b0;
        head_ptr          <= PW'(wrap_inc(int'(head_ptr), DEPTH));
      end
      if (link_en) begin
        ready_q[tail_ptr] <= 1'b1;
        tail_ptr          <= PW'(wrap_inc(int'(tail_ptr), DEPTH));
      end
    end
  end

endmodule

// File: rtl/txhq_ring_sched.sv
module txhq_ring_sched #(
  parameter int HANDLE_W   = 8,
  parameter int RING_DEPTH = 4,
  parameter int HOLD_DEPTH = 8,
  parameter int DROP_W     = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enq_valid,
  input  logic [HANDLE_W-1:0]             enq_handle,
  output logic                            enq_accept,
  output logic                            enq_drop,
  output logic                            ctl_desc_ready,
  output logic [HANDLE_W-1:0]             ctl_desc_handle,
  input  logic                            ctl_done,
  output logic                            rel_valid,
  output logic [HANDLE_W-1:0]             rel_handle,
  output logic [$clog2(RING_DEPTH+1)-1:0] ring_count,
  output logic [$clog2(HOLD_DEPTH+1)-1:0] hold_count,
  output logic [DROP_W-1:0]               drop_count
);
  import txhq_pkg::*;

  localparam int RCW = $clog2(RING_DEPTH + 1);
  localparam int HCW = $clog2(HOLD_DEPTH + 1);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  // Named internal events, observed by the bound checker.
  logic                retire_ok;
  logic                hold_pop;
  logic                hold_push;
  logic                ring_link;
  logic [HANDLE_W-1:0] link_handle;
  logic [HANDLE_W-1:0] hold_head;
  route_e              route;
  int                  hold_after;
  int                  ring_after;

  logic [RCW-1:0] ring_cnt;
  logic [HCW-1:0] hold_cnt;

  // Refill first, then route the new packet against what is left.
  always_comb begin
    hold_pop    = retire_ok && (hold_cnt != '0);
    hold_after  = int'(hold_cnt) - (hold_pop ? 1 : 0);
    ring_after  = int'(ring_cnt) - (retire_ok ? 1 : 0) + (hold_pop ? 1 : 0);
    route       = pick_route(enq_valid, hold_after, ring_after, HOLD_DEPTH, RING_DEPTH);
    hold_push   = (route == RT_HOLD);
    ring_link   = hold_pop || (route == RT_RING);
    link_handle = hold_pop ? hold_head : enq_handle;
  end

  assign enq_accept = (route == RT_RING) || (route == RT_HOLD);
  assign enq_drop   = (route == RT_DROP);

  txhq_desc_ring #(.W(HANDLE_W), .DEPTH(RING_DEPTH)) ring_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_en     (ring_link),
    .link_handle (link_handle),
    .done_req    (ctl_done),
    .retire_ok   (retire_ok),
    .head_ready  (ctl_desc_ready),
    .head_handle (ctl_desc_handle),
    .count       (ring_cnt)
  );

  txhq_hold_fifo #(.W(HANDLE_W), .DEPTH(HOLD_DEPTH)) hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (hold_push),
    .din   (enq_handle),
    .pop   (hold_pop),
    .dout  (hold_head),
    .count (hold_cnt)
  );

  logic                rel_valid_q;
  logic [HANDLE_W-1:0] rel_handle_q;
  logic [DROP_W-1:0]   drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_valid_q  <= 1'b0;
      rel_handle_q <= '0;
      drop_q       <= '0;
    end else begin
      rel_valid_q <= retire_ok;
      if (retire_ok) rel_handle_q <= ctl_desc_handle;
      if (enq_drop && drop_q != DROP_MAX) drop_q <= drop_q + DROP_W'(1);
    end
  end

  assign rel_valid  = rel_valid_q;
  assign rel_handle = rel_handle_q;
  assign drop_count = drop_q;
  assign ring_count = ring_cnt;
  assign hold_count = hold_cnt;

endmodule

// File: rtl/txhq_ring_sched_chk.sv
module txhq_ring_sched_chk #(
  parameter int HANDLE_W   = 8,
  parameter int RING_DEPTH = 4,
  parameter int HOLD_DEPTH = 8,
  parameter int DROP_W     = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            enq_valid,
  input logic                            enq_accept,
  input logic                            enq_drop,
  input logic                            ctl_desc_ready,
  input logic [HANDLE_W-1:0]             ctl_desc_handle,
  input logic                            ctl_done,
  input logic                            rel_valid,
  input logic [HANDLE_W-1:0]             rel_handle,
  input logic [$clog2(RING_DEPTH+1)-1:0] ring_count,
  input logic [$clog2(HOLD_DEPTH+1)-1:0] hold_count,
  input logic [DROP_W-1:0]               drop_count,
  input logic                            retire_ok,
  input logic                            hold_pop,
  input logic                            ring_link
);
  localparam int RCW = $clog2(RING_DEPTH + 1);
  localparam int HCW = $clog2(HOLD_DEPTH + 1);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  // R10
  hold_implies_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_count != '0) |-> (ring_count == RCW'(RING_DEPTH)));

  // R6
  ready_matches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_desc_ready == (ring_count != '0));

  // R7
  release_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_done && ctl_desc_ready) |=> (rel_valid && rel_handle == $past(ctl_desc_handle)));

  // R7
  no_stray_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_done && ctl_desc_ready) |=> !rel_valid);

  // R5
  drop_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_drop |-> (hold_count == HCW'(HOLD_DEPTH) && !enq_accept && !hold_pop));

  // R5
  drop_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_drop |=> ($past(drop_count) == DROP_MAX || drop_count == $past(drop_count) + DROP_W'(1)));

  // R2
  direct_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_accept && hold_count == '0 && ring_count < RCW'(RING_DEPTH) && !retire_ok)
      |=> (ring_count == $past(ring_count) + RCW'(1)));

  // R8
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_ok && hold_count != '0 && !enq_valid)
      |=> (ring_count == $past(ring_count) && hold_count == $past(hold_count) - HCW'(1)));

  // R10
  link_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_link |-> (ring_count < RCW'(RING_DEPTH) || retire_ok));

endmodule

bind txhq_ring_sched txhq_ring_sched_chk #(
  .HANDLE_W(HANDLE_W), .RING_DEPTH(RING_DEPTH), .HOLD_DEPTH(HOLD_DEPTH), .DROP_W(DROP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_accept(enq_accept),
  .enq_drop(enq_drop), .ctl_desc_ready(ctl_desc_ready), .ctl_desc_handle(ctl_desc_handle),
  .ctl_done(ctl_done), .rel_valid(rel_valid), .rel_handle(rel_handle),
  .ring_count(ring_count), .hold_count(hold_count), .drop_count(drop_count),
  .retire_ok(retire_ok), .hold_pop(hold_pop), .ring_link(ring_link)
);

// File: tb/txhq_ring_sched_tb_top.sv
module txhq_ring_sched_tb_top;
  localparam int HW = 8;
  localparam int RD = 4;
  localparam int HD = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                         rst_n;
  logic                         enq_valid, enq_accept, enq_drop;
  logic [HW-1:0]                enq_handle;
  logic                         ctl_desc_ready, ctl_done, rel_valid;
  logic [HW-1:0]                ctl_desc_handle, rel_handle;
  logic [$clog2(RD+1)-1:0]      ring_count;
  logic [$clog2(HD+1)-1:0]      hold_count;
  logic [DW-1:0]                drop_count;

  txhq_ring_sched #(.HANDLE_W(HW), .RING_DEPTH(RD), .HOLD_DEPTH(HD), .DROP_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_handle(enq_handle),
    .enq_accept(enq_accept), .enq_drop(enq_drop), .ctl_desc_ready(ctl_desc_ready),
    .ctl_desc_handle(ctl_desc_handle), .ctl_done(ctl_done), .rel_valid(rel_valid),
    .rel_handle(rel_handle), .ring_count(ring_count), .hold_count(hold_count),
    .drop_count(drop_count)
  );

  int n_tests = 0, n_fail = 0;
  int m_ring = 0, m_hold = 0, m_drop = 0;
  bit prev_pop = 0, exp_rel = 0, mon_on = 0;
  logic [HW-1:0] acc_q[$];   // accepted, not yet completed, in order
  logic [HW-1:0] rel_q[$];   // completed, release expected

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus with expected results computed up front.
  task automatic step(bit ev, logic [HW-1:0] h, bit dn);
    bit done_ok, pop, to_ring, to_hold, to_drop;
    int ha, ra;
    string tg;
    @(negedge clk);
    enq_valid = ev; enq_handle = h; ctl_done = dn;
    #1;
    chk(int'(ring_count) == m_ring, "R10", "ring_count", ring_count, m_ring);
    chk(int'(hold_count) == m_hold, prev_pop ? "R8" : "R10", "hold_count", hold_count, m_hold);
    chk(int'(drop_count) == m_drop, "R5", "drop_count", drop_count, m_drop);
    chk(ctl_desc_ready == (m_ring > 0), "R6", "ctl_desc_ready", ctl_desc_ready, m_ring > 0);
    if (m_ring > 0)
      chk(ctl_desc_handle == acc_q[0], "R6", "ctl_desc_handle", ctl_desc_handle, acc_q[0]);
    done_ok = dn && (m_ring > 0);
    pop     = done_ok && (m_hold > 0);
    ha = m_hold - (pop ? 1 : 0);
    ra = m_ring - (done_ok ? 1 : 0) + (pop ? 1 : 0);
    to_ring = ev && ha == 0 && ra < RD;
    to_hold = ev && !to_ring && ha < HD;
    to_drop = ev && !to_ring && !to_hold;
    if (to_ring)      tg = "R2";
    else if (to_hold) tg = (ha > 0) ? "R3" : "R4";
    else              tg = "R5";
    if (ev && done_ok) tg = "R9";
    chk(enq_accept == (to_ring || to_hold), tg, "enq_accept", enq_accept, to_ring || to_hold);
    chk(enq_drop == to_drop, tg, "enq_drop", enq_drop, to_drop);
    if (done_ok) rel_q.push_back(acc_q.pop_front());
    if (to_ring || to_hold) acc_q.push_back(h);
    @(posedge clk);
    exp_rel  = done_ok;
    prev_pop = pop;
    m_hold   = ha + (to_hold ? 1 : 0);
    m_ring   = ra + (to_ring ? 1 : 0);
    if (to_drop) m_drop++;
  endtask

  // Monitor: compares releases against the scoreboard.
  always @(negedge clk) begin
    if (mon_on) begin
      chk(rel_valid == exp_rel, "R7", "rel_valid", rel_valid, exp_rel);
      if (rel_valid && exp_rel && rel_q.size() > 0) begin
        logic [HW-1:0] e;
        e = rel_q.pop_front();
        chk(rel_handle == e, "R7", "rel_handle order", rel_handle, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual %0d cycles expected fewer", 20000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enq_valid = 1'b0; enq_handle = '0; ctl_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(ring_count == '0, "R1", "ring_count", ring_count, 0);
    chk(hold_count == '0, "R1", "hold_count", hold_count, 0);
    chk(drop_count == '0, "R1", "drop_count", drop_count, 0);
    chk(!ctl_desc_ready, "R1", "ctl_desc_ready", ctl_desc_ready, 0);
    chk(!rel_valid, "R1", "rel_valid", rel_valid, 0);
    mon_on = 1;
    for (int i = 0; i < RD; i++) step(1, HW'(8'h10 + i), 0);   // direct links
    for (int i = 0; i < HD; i++) step(1, HW'(8'h20 + i), 0);   // hold queue fill
    step(1, 8'hE0, 0);                                          // refused
    step(1, 8'hE1, 0);
    step(1, 8'h30, 1);                                          // full hold, refill then hold
    for (int i = 0; i < 3; i++) step(0, '0, 1);                 // plain refills
    for (int i = 0; i < 16; i++) step(0, '0, 1);                // drain, then stray dones
    step(1, 8'h50, 0);
    step(1, 8'h51, 1);                                          // completion frees slot, direct
    for (int i = 0; i < 4; i++) step(1, HW'(8'h58 + i), 0);    // ring full, one held
    step(1, 8'h5F, 1);                                          // one held: refill, new one held
    for (int i = 0; i < 24; i++) step(i % 3 != 2, HW'(8'h60 + i), i[0]);
    for (int i = 0; i < 16; i++) step(0, '0, 1);
    step(0, '0, 0);
    step(0, '0, 0);
    mon_on = 0;
    chk(rel_q.size() == 0, "R7", "pending releases", rel_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule